// File: doc/BRIEF.md
# Paper Tape Binary Loader

This block turns a stream of 8-bit tape characters into memory write requests. Two 6-bit frames form one 12-bit word: the first character of a pair is the upper frame and the second is the lower frame. A word with its thirteenth bit set does not go to memory. Its low twelve bits set the load origin instead. Every other word is written to a 15-bit address, made of a 3-bit field and the 12-bit origin.

A mode input, latched by a start pulse, picks one of two tape formats. The checksummed format skips rubouts, accepts field-change characters and ends with a checksum word followed by a trailer mark. The pair format holds plain address/data word pairs, with no checksum and no field. At the end of the tape the block raises `done` and a 2-bit status.

Tape characters arrive on a valid/ready handshake. A character is consumed on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_valid` and `in_char` stable until that edge. The block pulls `in_ready` low in four cases: while a memory write is outstanding, before the first start, after `done`, and during reset. Memory writes use a request/acknowledge pair. `wr_req`, `wr_addr` and `wr_data` stay constant until a cycle in which `wr_ack` is high. That cycle completes the write.

Top module: `tape_word_loader`

## Requirements
- R1: A word is assembled as (upper character << 6) | lower character. When the word is 010000 (octal) or larger, only the origin is loaded, from the word's low 12 bits, and no write is issued.
- R2: In checksummed mode, characters 000 and 0200 before the first other character are ignored. That first other character becomes the upper frame of the first word.
- R3: In checksummed mode, character 0377 is discarded, and so is the next character whatever its value. Neither character reaches the words or the checksum.
- R4: In checksummed mode, a character above 0200 other than 0377 selects the field held in its bits 5:3. The new field takes effect only after the next complete word has been processed.
- R5: In checksummed mode, a 0200 arriving in place of an upper frame ends the tape, and the word just assembled is not written. The status is 0 (OK) when the 12-bit sum of all earlier frames minus that word is zero modulo 4096, and 1 (checksum error) otherwise.
- R6: A data word is written to address {field, origin}. In checksummed mode the origin then increments modulo 4096 and stays within the same field.
- R7: A write whose address is at or above the parameter MEM_WORDS is not issued. The block finishes with status 2 (nonexistent memory).
- R8: In pair mode the leader ends at the first character that is nonzero and below 0200. Address words (above 07777) set the origin, and data words are written to field 0 at the origin with no increment. A character of 0200 or above in place of an upper frame ends the tape with status 0.
- R9: If `in_eos` is high while the block waits for a character and no character is offered, the block finishes with status 3 (format error).
- R10: While `wr_req` is high, `in_ready` is low, and `wr_addr` and `wr_data` stay stable until `wr_ack`.
- R11: After reset, `in_ready`, `wr_req` and `done` are low. A `start` pulse clears all parse state and latches `mode_pair`, and later changes of `mode_pair` have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a new tape |
| mode_pair | input | 1 | 1 = pair format, 0 = checksummed format; latched at start |
| in_valid | input | 1 | Tape character offered |
| in_ready | output | 1 | Block accepts a character this cycle |
| in_char | input | 8 | Tape character |
| in_eos | input | 1 | Level: the stream has no more characters |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 15 | Write address {field, origin} |
| wr_data | output | 12 | Write data |
| wr_ack | input | 1 | Write accepted this cycle |
| done | output | 1 | Tape finished; status valid |
| status | output | 2 | 0 OK, 1 checksum error, 2 nonexistent memory, 3 format error |

## Verification
A wrong origin or field shows up on the first data write after the error as a wrong `wr_addr`. A wrong deferred field shows up one word later than the field character that set it. A corrupted checksum accumulator is seen only at the trailer, through `status`, so every tape must end with a trailer that the bench has computed itself. A wrong rubout flag swallows or keeps the wrong frame, so the following word lands at the wrong address or with the wrong data, and the checksum verdict is also wrong.

// File: rtl/tape_ld_pkg.sv
package tape_ld_pkg;
  localparam int CHAR_W  = 8;
  localparam int FRAME_W = 6;
  localparam int WORD_W  = 2 * FRAME_W;
  localparam int FIELD_W = 3;
  localparam int ADDR_W  = FIELD_W + WORD_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_WRITE, ST_DONE
  } ld_state_t;

  typedef enum logic [1:0] {
    LD_OK = 2'd0, LD_CSUM = 2'd1, LD_NXM = 2'd2, LD_FMT = 2'd3
  } ld_status_t;
endpackage

// File: rtl/tape_char_class.sv
module tape_char_class
  import tape_ld_pkg::*;
(
  input  logic [CHAR_W-1:0]  ch,
  output logic               is_null,
  output logic               is_mark,
  output logic               is_upper,
  output logic               is_rubout,
  output logic               is_field,
  output logic [FIELD_W-1:0] field_val
);
  localparam logic [CHAR_W-1:0] MARK = CHAR_W'(1) << (CHAR_W - 1);

  always_comb begin
    is_null   = (ch == '0);
    is_mark   = (ch == MARK);
    is_upper  = (ch >= MARK);
    is_rubout = (ch == '1);
    is_field  = (ch > MARK) && !is_rubout;
    field_val = ch[FRAME_W-1 -: FIELD_W];
  end
endmodule

// File: rtl/tape_cksum.sv
module tape_cksum
  import tape_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [CHAR_W-1:0] hi,
  input  logic [CHAR_W-1:0] lo,
  output logic [WORD_W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum <= '0;
    else if (add_en)   sum <= sum + WORD_W'(hi) + WORD_W'(lo);
  end
endmodule

// File: rtl/tape_word_loader.sv
module tape_word_loader
  import tape_ld_pkg::*;
#(
  parameter int MEM_WORDS = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_pair,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_char,
  input  logic              in_eos,
  output logic              wr_req,
  output logic [14:0]       wr_addr,
  output logic [11:0]       wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic [1:0]        status
);
  localparam int           WIDE_W  = CHAR_W + FRAME_W;
  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W + 1)'(MEM_WORDS);

  ld_state_t            state_q;
  ld_status_t           status_q;
  logic                 pair_q, rub_q, done_q, wr_req_q;
  logic [CHAR_W-1:0]    high_q, low_q;
  logic [WORD_W-1:0]    origin_q, wr_data_q;
  logic [FIELD_W-1:0]   field_q, newf_q;
  logic [ADDR_W-1:0]    wr_addr_q;

  logic c_null, c_mark, c_upper, c_rub, c_fld;
  logic [FIELD_W-1:0]   c_fval;
  logic [WORD_W-1:0]    csum;
  logic                 take, csum_add;
  logic [WIDE_W-1:0]    bword, pword;
  logic [ADDR_W-1:0]    b_addr, p_addr;
  logic                 b_nxm, p_nxm;

  tape_char_class u_class (
    .ch(in_char), .is_null(c_null), .is_mark(c_mark), .is_upper(c_upper),
    .is_rubout(c_rub), .is_field(c_fld), .field_val(c_fval)
  );

  assign in_ready = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign take     = in_valid && in_ready;
  assign bword    = {high_q, FRAME_W'(0)} | WIDE_W'(low_q);
  assign pword    = {high_q, FRAME_W'(0)} | WIDE_W'(in_char);
  assign b_addr   = {field_q, origin_q};
  assign p_addr   = {FIELD_W'(0), origin_q};
  assign b_nxm    = {1'b0, b_addr} >= MEM_LIM;
  assign p_nxm    = {1'b0, p_addr} >= MEM_LIM;
  // a frame pair is summed when a non-trailer upper frame follows it
  assign csum_add = take && !pair_q && !rub_q && !c_rub && !c_fld &&
                    (state_q == ST_HIGH) && !c_mark;

  tape_cksum u_cksum (
    .clk(clk), .rst_n(rst_n), .clr(start), .add_en(csum_add),
    .hi(high_q), .lo(low_q), .sum(csum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  status_q <= LD_OK;  pair_q <= 1'b0;
      rub_q <= 1'b0;  done_q <= 1'b0;  wr_req_q <= 1'b0;
      high_q <= '0;  low_q <= '0;  origin_q <= '0;
      field_q <= '0;  newf_q <= '0;  wr_addr_q <= '0;  wr_data_q <= '0;
    end else if (start) begin
      state_q <= ST_LEAD;  status_q <= LD_OK;  pair_q <= mode_pair;
      rub_q <= 1'b0;  done_q <= 1'b0;  wr_req_q <= 1'b0;
      high_q <= '0;  low_q <= '0;  origin_q <= '0;
      field_q <= '0;  newf_q <= '0;
    end else if (state_q == ST_WRITE) begin
      if (wr_ack) begin
        wr_req_q <= 1'b0;
        state_q  <= pair_q ? ST_HIGH : ST_LOW;
      end
    end else if (take) begin
      if (!pair_q) begin
        if (rub_q)      rub_q  <= 1'b0;
        else if (c_rub) rub_q  <= 1'b1;
        else if (c_fld) newf_q <= c_fval;
        else begin
          unique case (state_q)
            ST_LEAD: begin
              high_q <= in_char;
              if (!c_null && !c_mark) state_q <= ST_LOW;
            end
            ST_LOW: begin
              low_q   <= in_char;
              state_q <= ST_HIGH;
            end
            default: begin
              if (c_mark) begin
                done_q   <= 1'b1;
                state_q  <= ST_DONE;
                status_q <= ((csum - bword[WORD_W-1:0]) == '0) ? LD_OK : LD_CSUM;
              end else begin
                field_q <= newf_q;
                high_q  <= in_char;
                state_q <= ST_LOW;
                if (|bword[WIDE_W-1:WORD_W]) origin_q <= bword[WORD_W-1:0];
                else if (b_nxm) begin
                  done_q <= 1'b1;  state_q <= ST_DONE;  status_q <= LD_NXM;
                end else begin
                  wr_req_q  <= 1'b1;
                  wr_addr_q <= b_addr;
                  wr_data_q <= bword[WORD_W-1:0];
                  origin_q  <= origin_q + 1'b1;
                  state_q   <= ST_WRITE;
                end
              end
            end
          endcase
        end
      end else begin
        unique case (state_q)
          ST_LEAD: begin
            high_q <= in_char;
            if (!c_null && !c_upper) state_q <= ST_LOW;
          end
          ST_LOW: begin
            state_q <= ST_HIGH;
            if (|pword[WIDE_W-1:WORD_W]) origin_q <= pword[WORD_W-1:0];
            else if (p_nxm) begin
              done_q <= 1'b1;  state_q <= ST_DONE;  status_q <= LD_NXM;
            end else begin
              wr_req_q  <= 1'b1;
              wr_addr_q <= p_addr;
              wr_data_q <= pword[WORD_W-1:0];
              state_q   <= ST_WRITE;
            end
          end
          default: begin
            if (c_upper) begin
              done_q <= 1'b1;  state_q <= ST_DONE;  status_q <= LD_OK;
            end else begin
              high_q  <= in_char;
              state_q <= ST_LOW;
            end
          end
        endcase
      end
    end else if (in_ready && in_eos) begin
      done_q   <= 1'b1;
      state_q  <= ST_DONE;
      status_q <= LD_FMT;
    end
  end

  assign wr_req  = wr_req_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign done    = done_q;
  assign status  = status_q;
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk #(
  parameter int MEM_WORDS = 32768
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_ready,
  input logic        wr_req,
  input logic        wr_ack,
  input logic [14:0] wr_addr,
  input logic [11:0] wr_data,
  input logic        done,
  input logic [1:0]  status
);
  a_r10_no_ready_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !in_ready);

  a_r10_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack && !start) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ({1'b0, wr_addr} < 16'(MEM_WORDS)));

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(status)));

  a_r11_done_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !wr_req));
endmodule

bind tape_word_loader tape_loader_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .status(status)
);

// File: tb/tape_word_loader_bench.sv
`timescale 1ns/1ps
module tape_word_loader_bench;
  localparam int MEMW = 8192;

  logic clk = 0, rst_n = 0, start = 0, mode_pair = 0;
  logic in_valid = 0, in_eos = 0, wr_ack = 0;
  logic [7:0] in_char = 0;
  logic in_ready, wr_req, done;
  logic [14:0] wr_addr;
  logic [11:0] wr_data;
  logic [1:0] status;

  always #2.5 clk = ~clk;

  tape_word_loader #(.MEM_WORDS(MEMW)) u_tape_word_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_pair(mode_pair),
    .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char), .in_eos(in_eos),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .status(status)
  );

  int total = 0, bad = 0, wr_cnt = 0, bp_bad = 0, ack_dly = 0, dly_cnt = 0;
  logic [11:0] mem_m [MEMW];
  logic [11:0] csum;

  always @(posedge clk) begin
    if (wr_req && wr_ack) begin
      mem_m[wr_addr[12:0]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (!wr_req || wr_ack) begin wr_ack <= 1'b0; dly_cnt <= 0; end
    else if (dly_cnt >= ack_dly) wr_ack <= 1'b1;
    else dly_cnt <= dly_cnt + 1;
  end

  always @(negedge clk) if (wr_req && in_ready) bp_bad <= bp_bad + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    int n = 0;
    @(negedge clk);
    in_valid = 1; in_char = c;
    while (!in_ready && n < 400) begin @(negedge clk); n++; end
    @(posedge clk);
    #0.5 in_valid = 0;
  endtask

  task automatic bw(input int w);   // checksummed word
    logic [7:0] hi, lo;
    hi = 8'((w >> 6) & 8'o177);
    lo = 8'(w & 8'o77);
    send(hi); send(lo);
    csum = csum + 12'(hi) + 12'(lo);
  endtask

  task automatic pw(input int w);   // pair-format word
    send(8'((w >> 6) & 8'o177)); send(8'(w & 8'o77));
  endtask

  task automatic trailer(input int delta);
    logic [11:0] t;
    t = csum + 12'(delta);
    send(8'(t >> 6)); send(8'(t & 12'o77)); send(8'o200);
  endtask

  task automatic do_start(input logic m);
    for (int i = 0; i < MEMW; i++) mem_m[i] = 12'o0;
    wr_cnt = 0; csum = 0;
    @(negedge clk); start = 1; mode_pair = m;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input int exp, input string tag);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(done && status == 2'(exp), tag, {29'b0, done, status}, 32'h4 | exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!in_ready && !wr_req && !done, "R11 reset outputs",
        {in_ready, wr_req, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!in_ready, "R11 idle before start", in_ready, 0);

    // R1 R2 R5 R6: checksummed sweep over fields and origins, incl. wrap
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 3; k++) begin
        int org, okc;
        org = (k == 0) ? 0 : (k == 1) ? 'o123 : 'o7775;
        ack_dly = k;
        do_start(0);
        send(8'o200); send(8'o200); send(8'o0); send(8'o200);
        if (f != 0) send(8'(8'o200 | (f << 3)));
        bw('o10000 | org);
        for (int i = 0; i < 4; i++) bw((org * 3 + i * 5 + f) & 'o7777);
        trailer(0);
        wait_done(0, "R5 good checksum status");
        chk(wr_cnt == 4, "R1 only data words written", wr_cnt, 4);
        okc = 1;
        for (int i = 0; i < 4; i++)
          if (mem_m[(f << 12) | ((org + i) & 'o7777)] != 12'((org * 3 + i * 5 + f) & 'o7777))
            okc = 0;
        chk(okc == 1, "R6 data at field|origin with increment", okc, 1);
      end
    end
    ack_dly = 0;

    // R5 bad checksum
    do_start(0);
    send(8'o0); bw('o10000 | 'o40); bw('o1111); bw('o2222);
    trailer(1);
    wait_done(1, "R5 checksum mismatch status");
    chk(mem_m['o41] == 12'o2222, "R5 data before bad trailer written", mem_m['o41], 'o2222);

    // R3 rubout handling
    do_start(0);
    send(8'o200); send(8'o377); send(8'o1);   // rubout in leader
    bw('o10000 | 'o200);
    send(8'o12); send(8'o377); send(8'o55);
    send(8'o377); send(8'o377);
    send(8'o377); send(8'o230);
    send(8'o34); csum = csum + 12'o12 + 12'o34;
    trailer(0);
    wait_done(0, "R3 rubouts excluded from checksum");
    chk(mem_m['o200] == 12'o1234, "R3 rubout and follower discarded", mem_m['o200], 'o1234);
    chk(wr_cnt == 1, "R3 no extra words", wr_cnt, 1);

    // R4 deferred field
    do_start(0);
    send(8'o0); bw('o10000 | 'o100); bw('o4321);
    send(8'o210);
    bw('o1357);
    trailer(0);
    wait_done(0, "R4 status");
    chk(mem_m['o100] == 12'o4321, "R4 word before field char in old field", mem_m['o100], 'o4321);
    chk(mem_m['o10101] == 12'o1357, "R4 next word in new field", mem_m['o10101], 'o1357);

    // R7 nonexistent memory
    do_start(0);
    send(8'o220); bw('o10000); bw('o7);
    send(8'o1);
    wait_done(2, "R7 nxm status");
    chk(wr_cnt == 0, "R7 no write issued", wr_cnt, 0);

    // R8 pair mode sweep
    for (int k = 0; k < 8; k++) begin
      int a, d;
      a = (k * 'o1234 + k) & 'o7777;
      if (k == 7) a = 'o7777;
      d = (a ^ 'o5252) & 'o7777;
      ack_dly = k & 1;
      do_start(1);
      send(8'o200); send(8'o0); send(8'o377);
      pw('o10000 | a); pw(d); pw((d + 1) & 'o7777);
      send((k & 1) ? 8'o377 : 8'o200);
      wait_done(0, "R8 pair end status");
      chk(mem_m[a] == 12'((d + 1) & 'o7777) && wr_cnt == 2,
          "R8 pair data at origin, no increment", mem_m[a], (d + 1) & 'o7777);
    end
    ack_dly = 0;

    // R9 early end of stream, both modes
    do_start(0);
    send(8'o0); send(8'o15);
    @(negedge clk); in_eos = 1;
    wait_done(3, "R9 eos in checksummed mode");
    in_eos = 0;
    do_start(1);
    send(8'o200);
    @(negedge clk); in_eos = 1;
    wait_done(3, "R9 eos in pair leader");
    in_eos = 0;

    // R11 mode latched at start; restart clears partial state
    do_start(1);
    send(8'o15);
    do_start(0);
    mode_pair = 1;
    send(8'o200);
    bw('o10000 | 'o300); bw('o6543);
    trailer(0);
    wait_done(0, "R11 latched checksummed mode");
    chk(mem_m['o300] == 12'o6543, "R11 mode change ignored mid tape", mem_m['o300], 'o6543);

    // R10 back-pressure observed throughout
    chk(bp_bad == 0, "R10 in_ready low during write", bp_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule